// File: doc/BRIEF.md
# Trace Port Control Register Block

This block is the software-visible control face of a debug trace port. A host reaches it over a plain 32-bit register bus: an address, separate read and write enables, write data, an access-size code and registered read data. Behind the bus sit a fixed revision word, a configuration register, a status word that always reads zero, an interrupt status and enable pair, and two byte-wide setup registers, one for clock control and one for serial framing. A level interrupt goes high whenever an enabled status bit is pending. Internal event lines set status bits, and software clears them by writing ones.

A write to the configuration register with bit 1 set acts as a soft reset. It returns every register to zero and then stores the written value masked with 0xFE. Only full-word accesses take effect. A narrower access produces a one-cycle size-error pulse and changes nothing. A word access to an address with no register behind it produces a one-cycle bad-access pulse and reads as zero. The trace data channels and any serial transmitter are outside this block.

Top module: `trace_ctl_regs`

## Requirements
- R1: After reset the configuration, interrupt status, interrupt enable, clock control and serial configuration registers read 0 and irqOut is low.
- R2: Offset 0x00 reads 0x00000010 at all times, and writes to it change nothing and raise no error.
- R3: A word write to offset 0x10 stores the write data ANDed with 0x000000FE. Bit 0 is always dropped.
- R4: A word write to offset 0x10 with data bit 1 set clears interrupt status, interrupt enable, clock control and serial configuration in the same cycle, stores data AND 0xFE in the configuration register, and leaves irqOut low afterwards.
- R5: Offset 0x14 always reads 0. Writes to it change nothing and raise no error.
- R6: Offset 0x18 is interrupt status. eventIn[i] high at a clock edge sets status bit i. A word write clears each status bit whose data bit is 1. A set and a clear of the same bit in one cycle leave the bit set.
- R7: A word write to offset 0x1C keeps only data bits 15:0 as the interrupt enable. The upper bits read back as 0.
- R8: irqOut is high exactly when status AND enable is nonzero. It follows each register update in the cycle after the clock edge that makes it.
- R9: Word writes to offsets 0x2C (clock control) and 0x30 (serial configuration) keep only data bits 7:0.
- R10: busSize encodes 2'b00 byte, 2'b01 halfword and 2'b10 word. Any read or write with busSize other than 2'b10 gives sizeErr high for exactly the next cycle, changes no register and reads 0.
- R11: A word access to any offset other than 0x00, 0x10, 0x14, 0x18, 0x1C, 0x2C and 0x30 (for example 0x24 or 0x28) gives badAccess high for exactly the next cycle, changes no register and reads 0. A narrow access raises only sizeErr.
- R12: Read data appears on busRdData in the cycle after busRdEn is sampled, and busRdData is 0 in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWrEn | input | 1 | Write request |
| busRdEn | input | 1 | Read request |
| busSize | input | 2 | Access size: 00 byte, 01 halfword, 10 word |
| busWrData | input | 32 | Write data |
| eventIn | input | EVT_W | Event lines that set low interrupt status bits |
| busRdData | output | 32 | Registered read data |
| sizeErr | output | 1 | One-cycle pulse after a narrow access |
| badAccess | output | 1 | One-cycle pulse after a word access to an undecoded offset |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench builds the block with EVT_W = 2 and leaves every other parameter at its default. The second event line lets the bench set an interrupt status bit other than bit 0. This shows that the write-one-to-clear mask acts bit by bit, and that a soft reset clears a pending bit it did not write. The 16-bit enable width places bits 31:16 of the enable write outside the kept field, so the bench can check that they are dropped.

// File: rtl/trace_ctl_pkg.sv
package trace_ctl_pkg;

  localparam int DATA_W = 32;

  localparam logic [1:0] SIZE_WORD = 2'b10;

  // Byte offsets of the decoded registers.
  localparam int OFF_REV   = 'h00;
  localparam int OFF_CFG   = 'h10;
  localparam int OFF_STAT  = 'h14;
  localparam int OFF_IRQST = 'h18;
  localparam int OFF_IRQEN = 'h1C;
  localparam int OFF_CLK   = 'h2C;
  localparam int OFF_SER   = 'h30;

  // Bit in the configuration write data that requests a soft reset.
  localparam int SOFT_RST_BIT = 1;

  localparam logic [7:0] CFG_KEEP = 8'hFE;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_REV,
    SEL_CFG,
    SEL_IRQST,
    SEL_IRQEN,
    SEL_CLK,
    SEL_SER
  } rdSel_e;

  // Strobes sent from the decoder to the datapath.
  typedef struct packed {
    logic   cfgWr;
    logic   softRst;
    logic   stClr;
    logic   enWr;
    logic   clkWr;
    logic   serWr;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;

endpackage

// File: rtl/trace_ctl_decode.sv
module trace_ctl_decode
  import trace_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busSize,
  input  logic              softRstBit,
  output regStrobe_t        strobe,
  output logic              sizeErr,
  output logic              badAccess
);

  localparam logic [ADDR_W-1:0] A_REV   = ADDR_W'(OFF_REV);
  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_IRQST = ADDR_W'(OFF_IRQST);
  localparam logic [ADDR_W-1:0] A_IRQEN = ADDR_W'(OFF_IRQEN);
  localparam logic [ADDR_W-1:0] A_CLK   = ADDR_W'(OFF_CLK);
  localparam logic [ADDR_W-1:0] A_SER   = ADDR_W'(OFF_SER);

  logic   access;
  logic   wordOk;
  logic   known;
  logic   wrGo;
  rdSel_e sel;
  logic   sizeErrD;
  logic   badD;

  assign access = busWrEn | busRdEn;
  assign wordOk = (busSize == SIZE_WORD);
  assign wrGo   = busWrEn & wordOk;

  always_comb begin
    known = 1'b1;
    sel   = SEL_ZERO;
    case (busAddr)
      A_REV:   sel = SEL_REV;
      A_CFG:   sel = SEL_CFG;
      A_STAT:  sel = SEL_ZERO;
      A_IRQST: sel = SEL_IRQST;
      A_IRQEN: sel = SEL_IRQEN;
      A_CLK:   sel = SEL_CLK;
      A_SER:   sel = SEL_SER;
      default: known = 1'b0;
    endcase
  end

  always_comb begin
    strobe         = '0;
    strobe.rdSel   = SEL_ZERO;
    strobe.rdEn    = busRdEn;
    if (busRdEn && wordOk && known) strobe.rdSel = sel;
    if (wrGo && known) begin
      strobe.cfgWr   = (sel == SEL_CFG);
      strobe.softRst = (sel == SEL_CFG) & softRstBit;
      strobe.stClr   = (sel == SEL_IRQST);
      strobe.enWr    = (sel == SEL_IRQEN);
      strobe.clkWr   = (sel == SEL_CLK);
      strobe.serWr   = (sel == SEL_SER);
    end
  end

  assign sizeErrD = access & ~wordOk;
  assign badD     = access & wordOk & ~known;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sizeErr   <= 1'b0;
      badAccess <= 1'b0;
    end else begin
      sizeErr   <= sizeErrD;
      badAccess <= badD;
    end
  end

endmodule

// File: rtl/trace_ctl_datapath.sv
module trace_ctl_datapath
  import trace_ctl_pkg::*;
#(
  parameter int          ENABLE_W  = 16,
  parameter int          NARROW_W  = 8,
  parameter int          EVT_W     = 1,
  parameter logic [31:0] REV_VALUE = 32'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [EVT_W-1:0]  eventIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam int CFG_W = 8;

  logic [CFG_W-1:0]    cfgQ;
  logic [ENABLE_W-1:0] stQ;
  logic [ENABLE_W-1:0] enQ;
  logic [NARROW_W-1:0] clkQ;
  logic [NARROW_W-1:0] serQ;
  logic [DATA_W-1:0]   rdMux;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfgQ <= '0;
    else if (strobe.cfgWr) cfgQ <= wrData[CFG_W-1:0] & CFG_KEEP;
  end

  // One status bit per generate step; low bits also have an event set.
  for (genvar i = 0; i < ENABLE_W; i++) begin : g_stat
    if (i < EVT_W) begin : g_evt
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          stQ[i] <= 1'b0;
        else if (strobe.softRst)            stQ[i] <= 1'b0;
        else if (eventIn[i])                stQ[i] <= 1'b1;
        else if (strobe.stClr && wrData[i]) stQ[i] <= 1'b0;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                          stQ[i] <= 1'b0;
        else if (strobe.softRst)            stQ[i] <= 1'b0;
        else if (strobe.stClr && wrData[i]) stQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ  <= '0;
      clkQ <= '0;
      serQ <= '0;
    end else if (strobe.softRst) begin
      enQ  <= '0;
      clkQ <= '0;
      serQ <= '0;
    end else begin
      if (strobe.enWr)  enQ  <= wrData[ENABLE_W-1:0];
      if (strobe.clkWr) clkQ <= wrData[NARROW_W-1:0];
      if (strobe.serWr) serQ <= wrData[NARROW_W-1:0];
    end
  end

  assign irqOut = |(stQ & enQ);

  always_comb begin
    case (strobe.rdSel)
      SEL_REV:   rdMux = REV_VALUE;
      SEL_CFG:   rdMux = DATA_W'(cfgQ);
      SEL_IRQST: rdMux = DATA_W'(stQ);
      SEL_IRQEN: rdMux = DATA_W'(enQ);
      SEL_CLK:   rdMux = DATA_W'(clkQ);
      SEL_SER:   rdMux = DATA_W'(serQ);
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strobe.rdEn) rdData <= rdMux;
    else                  rdData <= '0;
  end

endmodule

// File: rtl/trace_ctl_regs.sv
module trace_ctl_regs
  import trace_ctl_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          ENABLE_W  = 16,
  parameter int          NARROW_W  = 8,
  parameter int          EVT_W     = 1,
  parameter logic [31:0] REV_VALUE = 32'h10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWrData,
  input  logic [EVT_W-1:0]  eventIn,
  output logic [31:0]       busRdData,
  output logic              sizeErr,
  output logic              badAccess,
  output logic              irqOut
);

  regStrobe_t strobe;

  trace_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk        (clk),
    .rstN       (rstN),
    .busAddr    (busAddr),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busSize    (busSize),
    .softRstBit (busWrData[SOFT_RST_BIT]),
    .strobe     (strobe),
    .sizeErr    (sizeErr),
    .badAccess  (badAccess)
  );

  trace_ctl_datapath #(
    .ENABLE_W  (ENABLE_W),
    .NARROW_W  (NARROW_W),
    .EVT_W     (EVT_W),
    .REV_VALUE (REV_VALUE)
  ) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (busWrData),
    .eventIn (eventIn),
    .rdData  (busRdData),
    .irqOut  (irqOut)
  );

endmodule

// File: rtl/trace_ctl_regs_chk.sv
module trace_ctl_regs_chk #(
  parameter int ADDR_W   = 8,
  parameter int ENABLE_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [1:0]        busSize,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              sizeErr,
  input logic              badAccess,
  input logic              irqOut
);

  localparam logic [ADDR_W-1:0] A_REV  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_HOLE = ADDR_W'('h24);

  logic wordAcc;
  assign wordAcc = (busWrEn | busRdEn) && (busSize == 2'b10);

  p_rev_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busSize == 2'b10 && busAddr == A_REV |=> busRdData == 32'h10);

  p_stat_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busSize == 2'b10 && busAddr == A_STAT |=> busRdData == 32'h0);

  p_softrst_irq_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busSize == 2'b10 && busAddr == A_CFG && busWrData[1] |=> !irqOut);

  p_irq_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && busSize == 2'b10 && busAddr == A_EN && busWrData[ENABLE_W-1:0] == '0
    |=> !irqOut);

  p_size_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn | busRdEn) && busSize != 2'b10 |=> sizeErr && !badAccess);

  p_size_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !((busWrEn | busRdEn) && busSize != 2'b10) |=> !sizeErr);

  p_hole_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    wordAcc && busAddr == A_HOLE |=> badAccess);

  p_narrow_read_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busSize != 2'b10 |=> busRdData == 32'h0);

  p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> busRdData == 32'h0);

endmodule

bind trace_ctl_regs trace_ctl_regs_chk #(.ADDR_W(ADDR_W), .ENABLE_W(ENABLE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busSize   (busSize),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .sizeErr   (sizeErr),
  .badAccess (badAccess),
  .irqOut    (irqOut)
);

// File: tb/tb_trace_ctl_regs.sv
module tb_trace_ctl_regs;

  localparam int CLK_PERIOD = 10;
  localparam int EVT_W      = 2;
  localparam int NVEC       = 17;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busSize = 2'b10;
  logic [31:0] busWrData = '0;
  logic [EVT_W-1:0] eventIn = '0;
  logic [31:0] busRdData;
  logic        sizeErr;
  logic        badAccess;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_ctl_regs #(.EVT_W(EVT_W)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busSize(busSize), .busWrData(busWrData),
    .eventIn(eventIn), .busRdData(busRdData), .sizeErr(sizeErr),
    .badAccess(badAccess), .irqOut(irqOut)
  );

  // Vector: {isRead, addr[7:0], wdata[31:0], expect[31:0]}
  localparam logic [72:0] VEC [0:NVEC-1] = '{
    {1'b0, 8'h10, 32'h0000_00FD, 32'h0},           // R3
    {1'b1, 8'h10, 32'h0,         32'h0000_00FC},   // R3
    {1'b0, 8'h1C, 32'hABCD_1234, 32'h0},           // R7
    {1'b1, 8'h1C, 32'h0,         32'h0000_1234},   // R7
    {1'b0, 8'h2C, 32'h1234_56A5, 32'h0},           // R9
    {1'b1, 8'h2C, 32'h0,         32'h0000_00A5},   // R9
    {1'b0, 8'h30, 32'hFFFF_FF3C, 32'h0},           // R9
    {1'b1, 8'h30, 32'h0,         32'h0000_003C},   // R9
    {1'b0, 8'h00, 32'hFFFF_FFFF, 32'h0},           // R2
    {1'b1, 8'h00, 32'h0,         32'h0000_0010},   // R2
    {1'b0, 8'h14, 32'hFFFF_FFFF, 32'h0},           // R5
    {1'b1, 8'h14, 32'h0,         32'h0},           // R5
    {1'b0, 8'h10, 32'h0000_0003, 32'h0},           // R4
    {1'b1, 8'h10, 32'h0,         32'h0000_0002},   // R4
    {1'b1, 8'h1C, 32'h0,         32'h0},           // R4
    {1'b1, 8'h2C, 32'h0,         32'h0},           // R4
    {1'b1, 8'h30, 32'h0,         32'h0}            // R4
  };
  localparam int VREQ [0:NVEC-1] = '{3,3,7,7,9,9,9,9,2,2,5,5,4,4,4,4,4};

  function automatic string reqName(input int n);
    case (n)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    busAddr = a; busWrData = d; busSize = sz; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busSize = 2'b10;
  endtask

  task automatic doRead(input logic [7:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busSize = sz; busRdEn = 1'b1;
    @(negedge clk);
    d = busRdData;
    busRdEn = 1'b0; busSize = 2'b10;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1", {31'b0, irqOut}, 32'h0);
    doRead(8'h10, 2'b10, d); check("R1", d, 32'h0);
    doRead(8'h18, 2'b10, d); check("R1", d, 32'h0);
    doRead(8'h1C, 2'b10, d); check("R1", d, 32'h0);
    doRead(8'h2C, 2'b10, d); check("R1", d, 32'h0);
    doRead(8'h30, 2'b10, d); check("R1", d, 32'h0);

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][72]) begin
        doRead(VEC[i][71:64], 2'b10, d);
        check(reqName(VREQ[i]), d, VEC[i][31:0]);
      end else begin
        doWrite(VEC[i][71:64], VEC[i][63:32], 2'b10);
        if (VEC[i][71:64] == 8'h00 || VEC[i][71:64] == 8'h14)
          check(reqName(VREQ[i]), {30'b0, sizeErr, badAccess}, 32'h0);
      end
    end

    // R6 / R8: event sets status, irq follows, write-one-to-clear
    doWrite(8'h1C, 32'h0000_0003, 2'b10);
    @(negedge clk); eventIn = 2'b01;
    @(negedge clk); eventIn = 2'b00;
    check("R8", {31'b0, irqOut}, 32'h1);
    doRead(8'h18, 2'b10, d); check("R6", d, 32'h1);
    doWrite(8'h18, 32'hFFFF_FFFE, 2'b10);
    doRead(8'h18, 2'b10, d); check("R6", d, 32'h1);
    doWrite(8'h18, 32'h0000_0001, 2'b10);
    check("R8", {31'b0, irqOut}, 32'h0);
    doRead(8'h18, 2'b10, d); check("R6", d, 32'h0);

    // R6: set and clear in the same cycle keep the bit set
    @(negedge clk);
    eventIn = 2'b01; busAddr = 8'h18; busWrData = 32'h1; busSize = 2'b10; busWrEn = 1'b1;
    @(negedge clk);
    eventIn = 2'b00; busWrEn = 1'b0;
    doRead(8'h18, 2'b10, d); check("R6", d, 32'h1);

    // R8: dropping enable lowers irq with status still pending
    doWrite(8'h1C, 32'h0, 2'b10);
    check("R8", {31'b0, irqOut}, 32'h0);

    // R4: soft reset clears a pending bit on the second event line
    doWrite(8'h1C, 32'h0000_0002, 2'b10);
    @(negedge clk); eventIn = 2'b10;
    @(negedge clk); eventIn = 2'b00;
    check("R8", {31'b0, irqOut}, 32'h1);
    doWrite(8'h10, 32'h0000_0002, 2'b10);
    check("R4", {31'b0, irqOut}, 32'h0);
    doRead(8'h18, 2'b10, d); check("R4", d, 32'h0);

    // R10: narrow accesses
    doWrite(8'h2C, 32'h0000_0077, 2'b00);
    check("R10", {30'b0, sizeErr, badAccess}, 32'h2);
    @(negedge clk);
    check("R10", {31'b0, sizeErr}, 32'h0);
    doRead(8'h2C, 2'b10, d); check("R10", d, 32'h0);
    doWrite(8'h1C, 32'h0000_FFFF, 2'b01);
    doRead(8'h1C, 2'b10, d); check("R10", d, 32'h0);
    doRead(8'h00, 2'b01, d); check("R10", d, 32'h0);
    check("R10", {30'b0, sizeErr, badAccess}, 32'h2);
    doRead(8'h24, 2'b00, d);
    check("R11", {30'b0, sizeErr, badAccess}, 32'h2);

    // R11: undecoded offsets
    doWrite(8'h24, 32'hFFFF_FFFF, 2'b10);
    check("R11", {30'b0, sizeErr, badAccess}, 32'h1);
    @(negedge clk);
    check("R11", {31'b0, badAccess}, 32'h0);
    doRead(8'h28, 2'b10, d); check("R11", d, 32'h0);
    check("R11", {31'b0, badAccess}, 32'h1);
    doRead(8'h11, 2'b10, d); check("R11", d, 32'h0);
    check("R11", {31'b0, badAccess}, 32'h1);
    doRead(8'h10, 2'b10, d); check("R11", d, 32'h2);

    // R12: no read leaves read data at zero
    doRead(8'h00, 2'b10, d); check("R12", d, 32'h10);
    @(negedge clk);
    check("R12", busRdData, 32'h0);

    finish();
  end

endmodule